// File: doc/BRIEF.md
# Character-Synchronous Receive Block Framer

This block sits behind a character-synchronous receiver that already delivers byte-aligned characters. It removes idle SYN fill, recognises the end of each block through a small programmable table of control characters, accumulates a 16-bit block check over the payload and compares it against the two check bytes that close the block. In transparent mode the escape character DLE introduces every control character. The DLE itself is taken out of both the data stream and the check, so that arbitrary binary payload can pass through.

Software starts each block with a per-character interrupt enabled and looks at the leading characters. Once it knows the block type, it either switches on transparent mode or pulses the check-reset command on the current character (for example SOH). It then masks the interrupt and lets the framer run to the end of the block. Each accepted byte appears on the output strobe for buffer write. The block end is signalled by a one-cycle pulse with an error flag. An abort character or a line turnaround sends the framer back to its hunt state.

The controller has five states. HUNT waits for a SYN and then moves to DATA. DATA moves to ESC on a DLE in transparent mode, to CHK1 on a control character that takes a check, and back to HUNT on a control character without one. ESC returns to DATA after an escaped data byte, and moves to CHK1 or HUNT on an escaped control character. CHK1 moves to CHK2 after the first check byte. CHK2 moves to DATA after the second check byte. A line turnaround moves any state to HUNT.

Top module: `bsc_rx_framer`

## Requirements
- R1: After reset the framer is in HUNT and discards every byte until a SYN (0x16) arrives. Outside the check bytes, a SYN is never written out and never enters the check.
- R2: With transparent mode off, a byte that equals an entry whose valid bit is set is a control character. It is written out and included in the check. A byte that matches only an invalid entry is plain data.
- R3: With transparent mode on, a DLE (0x10) is not written out and not included in the check. The byte after it is written out and checked: DLE DLE yields one DLE, and DLE SYN is dropped as fill.
- R4: With transparent mode on, a control-valued byte counts as control only directly after a DLE. A bare control-valued byte is plain data.
- R5: The check is CRC-16, polynomial x^16+x^15+x^2+1, processed least significant bit first, with an initial value of zero. After a control character whose entry has its check flag set, the next two bytes are check bytes and are not written out. One cycle after the second check byte, blk_end pulses for one cycle. crc_err is high with blk_end when the remainder is nonzero. The check is then cleared for the next block.
- R6: When crc_reset_cmd is high with a data byte, the check is cleared and that byte is left out of it. The byte is still written out.
- R7: When mode_excl_en is set, a data byte equal to excl_char is written out but left out of the check.
- R8: A control character whose entry has its check flag clear (for example ENQ, 0x05) is written out. One cycle later it pulses blk_abort and hunt_req, and the framer re-enters HUNT with a cleared check.
- R9: line_turn has priority over any received byte. It moves the framer to HUNT, clears the check, and pulses hunt_req on the next cycle.
- R10: char_irq pulses together with every out_valid while char_irq_en is set. It stays low while char_irq_en is clear.
- R11: Every output is registered and appears one clock after the input byte that causes it. All outputs are low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| mode_transp | input | 1 | Transparent receive mode |
| mode_excl_en | input | 1 | Enable exclusion of excl_char from the check |
| excl_char | input | 8 | Character left out of the check |
| crc_reset_cmd | input | 1 | Clear the check and exclude the current byte |
| char_irq_en | input | 1 | Per-character interrupt enable |
| line_turn | input | 1 | Line turnaround, forces HUNT |
| ctl_chars | input | NUM_CTL*8 | Control character table, entry i at bits 8i+7:8i |
| ctl_valid | input | NUM_CTL | Entry valid bits |
| ctl_chk | input | NUM_CTL | Entry check-follows flags |
| out_valid | output | 1 | Byte for buffer write |
| out_data | output | 8 | Output byte |
| char_irq | output | 1 | Per-character interrupt pulse |
| blk_end | output | 1 | Block closed after check bytes |
| crc_err | output | 1 | Check remainder nonzero, valid with blk_end |
| blk_abort | output | 1 | Block aborted by a control character without a check |
| hunt_req | output | 1 | Framer entered HUNT |

## Verification
The bench builds the framer with NUM_CTL=5. Entries for ETX, ITB and ETB have the check flag set, ENQ has it clear, and a fifth entry holds a printable character with its valid bit cleared. This brings the invalid-entry path, both flag values and both escape outcomes within reach. Blocks run in both modes, with good and corrupted check bytes, with the reset command and the exclusion character, and with aborts and turnarounds followed by hunt-state discards.

// File: rtl/bsc_rx_pkg.sv
package bsc_rx_pkg;

    localparam logic [7:0]  CH_SYN       = 8'h16;
    localparam logic [7:0]  CH_DLE       = 8'h10;
    localparam int          CRC_W        = 16;
    localparam logic [15:0] CRC_POLY_REF = 16'hA001;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_DATA,
        ST_ESC,
        ST_CHK1,
        ST_CHK2
    } rx_state_e;

    // Folds one byte into the check, least significant bit first.
    function automatic logic [CRC_W-1:0] crc_fold_byte(input logic [CRC_W-1:0] c,
                                                       input logic [7:0] b);
        logic [CRC_W-1:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            if (r[0] ^ b[i]) r = (r >> 1) ^ CRC_POLY_REF;
            else             r = r >> 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/bsc_ctl_match.sv
module bsc_ctl_match #(
    parameter int NUM_CTL = 4
) (
    input  logic [7:0]           byte_in,
    input  logic [NUM_CTL*8-1:0] tab_chars,
    input  logic [NUM_CTL-1:0]   tab_valid,
    input  logic [NUM_CTL-1:0]   tab_chk,
    output logic                 hit,
    output logic                 hit_chk
);
    logic [NUM_CTL-1:0] eq;

    generate
        for (genvar g = 0; g < NUM_CTL; g++) begin : g_entry
            assign eq[g] = tab_valid[g] && (tab_chars[g*8 +: 8] == byte_in);
        end
    endgenerate

    assign hit     = |eq;
    assign hit_chk = |(eq & tab_chk);
endmodule

// File: rtl/bsc_crc_acc.sv
module bsc_crc_acc
    import bsc_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             fold,
    input  logic [7:0]       din,
    output logic [CRC_W-1:0] crc_nxt
);
    logic [CRC_W-1:0] crc_q;

    assign crc_nxt = crc_fold_byte(crc_q, din);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    crc_q <= '0;
        else if (clr)  crc_q <= '0;
        else if (fold) crc_q <= crc_nxt;
    end
endmodule

// File: rtl/bsc_rx_framer.sv
module bsc_rx_framer
    import bsc_rx_pkg::*;
#(
    parameter int NUM_CTL = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_valid,
    input  logic [7:0]           rx_data,
    input  logic                 mode_transp,
    input  logic                 mode_excl_en,
    input  logic [7:0]           excl_char,
    input  logic                 crc_reset_cmd,
    input  logic                 char_irq_en,
    input  logic                 line_turn,
    input  logic [NUM_CTL*8-1:0] ctl_chars,
    input  logic [NUM_CTL-1:0]   ctl_valid,
    input  logic [NUM_CTL-1:0]   ctl_chk,
    output logic                 out_valid,
    output logic [7:0]           out_data,
    output logic                 char_irq,
    output logic                 blk_end,
    output logic                 crc_err,
    output logic                 blk_abort,
    output logic                 hunt_req
);
    rx_state_e        state_q, state_d;
    logic             hit, hit_chk;
    logic             crc_clr, crc_fold;
    logic [CRC_W-1:0] crc_nxt;
    logic             vld_d, end_d, err_d, abort_d, hunt_d;

    bsc_ctl_match #(.NUM_CTL(NUM_CTL)) i_match (
        .byte_in   (rx_data),
        .tab_chars (ctl_chars),
        .tab_valid (ctl_valid),
        .tab_chk   (ctl_chk),
        .hit       (hit),
        .hit_chk   (hit_chk)
    );

    bsc_crc_acc i_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (crc_clr),
        .fold    (crc_fold),
        .din     (rx_data),
        .crc_nxt (crc_nxt)
    );

    // Next state and next outputs
    always_comb begin
        state_d  = state_q;
        vld_d    = 1'b0;
        end_d    = 1'b0;
        err_d    = 1'b0;
        abort_d  = 1'b0;
        hunt_d   = 1'b0;
        crc_clr  = 1'b0;
        crc_fold = 1'b0;
        if (line_turn) begin
            state_d = ST_HUNT;
            hunt_d  = 1'b1;
            crc_clr = 1'b1;
        end else if (rx_valid) begin
            unique case (state_q)
                ST_HUNT: begin
                    crc_clr = 1'b1;
                    if (rx_data == CH_SYN) state_d = ST_DATA;
                end
                ST_DATA, ST_ESC: begin
                    if (rx_data == CH_SYN) begin
                        state_d = ST_DATA;
                    end else if (state_q == ST_DATA && mode_transp && rx_data == CH_DLE) begin
                        state_d = ST_ESC;
                    end else if (hit && (state_q == ST_ESC || !mode_transp)) begin
                        vld_d = 1'b1;
                        if (hit_chk) begin
                            crc_fold = 1'b1;
                            state_d  = ST_CHK1;
                        end else begin
                            abort_d = 1'b1;
                            hunt_d  = 1'b1;
                            crc_clr = 1'b1;
                            state_d = ST_HUNT;
                        end
                    end else begin
                        vld_d   = 1'b1;
                        state_d = ST_DATA;
                        if (crc_reset_cmd)
                            crc_clr = 1'b1;
                        else if (!(mode_excl_en && rx_data == excl_char))
                            crc_fold = 1'b1;
                    end
                end
                ST_CHK1: begin
                    crc_fold = 1'b1;
                    state_d  = ST_CHK2;
                end
                ST_CHK2: begin
                    crc_clr = 1'b1;
                    end_d   = 1'b1;
                    err_d   = (crc_nxt != '0);
                    state_d = ST_DATA;
                end
                default: state_d = ST_HUNT;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HUNT;
        else        state_q <= state_d;
    end

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            char_irq  <= 1'b0;
            blk_end   <= 1'b0;
            crc_err   <= 1'b0;
            blk_abort <= 1'b0;
            hunt_req  <= 1'b0;
        end else begin
            out_valid <= vld_d;
            out_data  <= vld_d ? rx_data : '0;
            char_irq  <= vld_d && char_irq_en;
            blk_end   <= end_d;
            crc_err   <= err_d;
            blk_abort <= abort_d;
            hunt_req  <= hunt_d;
        end
    end

    AST_SYN_NEVER_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_data != CH_SYN); // R1

    AST_DLE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !line_turn && state_q == ST_DATA && mode_transp && rx_data == CH_DLE)
        |=> !out_valid); // R3

    AST_END_AFTER_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
        blk_end |-> $past(state_q == ST_CHK2) && state_q == ST_DATA); // R5

    AST_ERR_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        crc_err |-> blk_end); // R5

    AST_ABORT_HUNTS: assert property (@(posedge clk) disable iff (!rst_n)
        blk_abort |-> hunt_req && state_q == ST_HUNT && out_valid); // R8

    AST_TURN_TO_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
        line_turn |=> hunt_req && state_q == ST_HUNT && !out_valid); // R9

    AST_IRQ_WITH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        char_irq |-> out_valid && $past(char_irq_en)); // R10
endmodule

// File: tb/test_bsc_rx_framer.sv
module test_bsc_rx_framer;
    localparam int CLK_PERIOD = 10;
    localparam int NCTL = 5;
    localparam logic [7:0] SYN = 8'h16, DLE = 8'h10, SOH = 8'h01, STX = 8'h02,
                           ETX = 8'h03, ETB = 8'h17, ENQ = 8'h05, ITB = 8'h1F;

    logic clk = 1'b0, rst_n = 1'b0;
    logic rx_valid = 1'b0, mode_transp = 1'b0, mode_excl_en = 1'b0;
    logic crc_reset_cmd = 1'b0, char_irq_en = 1'b0, line_turn = 1'b0;
    logic [7:0] rx_data = '0, excl_char = '0;
    logic [NCTL*8-1:0] ctl_chars = {8'h4D, ENQ, ETB, ITB, ETX};
    logic [NCTL-1:0]   ctl_valid = 5'b01111;
    logic [NCTL-1:0]   ctl_chk   = 5'b00111;
    logic out_valid, char_irq, blk_end, crc_err, blk_abort, hunt_req;
    logic [7:0] out_data;

    int checks = 0, errors = 0;
    bit done = 0;
    bit irq_exp = 0;
    logic [15:0] bcrc = '0;

    int         q_kind[$];
    logic [7:0] q_val[$];
    string      q_req[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    bsc_rx_framer #(.NUM_CTL(NCTL)) i_bsc_rx_framer (
        .clk, .rst_n, .rx_valid, .rx_data, .mode_transp, .mode_excl_en, .excl_char,
        .crc_reset_cmd, .char_irq_en, .line_turn, .ctl_chars, .ctl_valid, .ctl_chk,
        .out_valid, .out_data, .char_irq, .blk_end, .crc_err, .blk_abort, .hunt_req
    );

    function automatic logic [15:0] bench_crc(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r = c;
        for (int i = 0; i < 8; i++)
            r = ((r[0] ^ b[i]) != 1'b0) ? ((r >> 1) ^ 16'hA001) : (r >> 1);
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic push(input int k, input logic [7:0] v, input string req);
        q_kind.push_back(k); q_val.push_back(v); q_req.push_back(req);
    endtask

    task automatic exp_data(input logic [7:0] b, input bit incl, input string req);
        push(0, b, req);
        if (incl) bcrc = bench_crc(bcrc, b);
    endtask

    task automatic send(input logic [7:0] b, input bit cmd = 1'b0);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = b; crc_reset_cmd = cmd;
        @(negedge clk);
        rx_valid = 1'b0; crc_reset_cmd = 1'b0;
    endtask

    task automatic send_check(input bit corrupt, input string req);
        logic [7:0] lo = bcrc[7:0];
        logic [7:0] hi = bcrc[15:8] ^ (corrupt ? 8'h01 : 8'h00);
        push(1, {7'd0, corrupt}, req);
        send(lo);
        send(hi);
        bcrc = '0;
    endtask

    // Monitor: pops the scoreboard as results appear
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (out_valid) begin
                if (q_kind.size() == 0) chk(0, "R1", "unexpected byte", out_data, 0);
                else begin
                    chk(q_kind[0] == 0 && q_val[0] == out_data, q_req[0], "data byte", out_data, q_val[0]);
                    chk(char_irq == irq_exp, "R10", "char_irq", char_irq, irq_exp);
                    void'(q_kind.pop_front()); void'(q_val.pop_front()); void'(q_req.pop_front());
                end
            end else if (char_irq) chk(0, "R10", "irq without byte", 1, 0);
            if (blk_end) begin
                if (q_kind.size() == 0) chk(0, "R5", "unexpected blk_end", 1, 0);
                else begin
                    chk(q_kind[0] == 1 && q_val[0][0] == crc_err, q_req[0], "crc_err at blk_end", crc_err, q_val[0][0]);
                    void'(q_kind.pop_front()); void'(q_val.pop_front()); void'(q_req.pop_front());
                end
            end
            if (blk_abort) begin
                if (q_kind.size() == 0) chk(0, "R8", "unexpected blk_abort", 1, 0);
                else begin
                    chk(q_kind[0] == 2, q_req[0], "blk_abort", 1, q_kind[0] == 2);
                    void'(q_kind.pop_front()); void'(q_val.pop_front()); void'(q_req.pop_front());
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL R11 watchdog: actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk({out_valid, char_irq, blk_end, crc_err, blk_abort, hunt_req} == 6'b0, "R11", "reset outputs",
            {out_valid, char_irq, blk_end, crc_err, blk_abort, hunt_req}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 R2 R6 R10: plain block with check reset on SOH, interrupts on
        char_irq_en = 1'b1; irq_exp = 1'b1;
        send(8'h41);                       // R1 discarded in HUNT
        send(SYN);
        send(SYN);                         // R1 stripped
        exp_data(SOH, 0, "R6"); send(SOH, 1'b1); bcrc = '0;
        exp_data(8'h41, 1, "R2"); send(8'h41);
        exp_data(8'h42, 1, "R2"); send(8'h42);
        exp_data(STX, 1, "R2"); send(STX);
        exp_data(8'h4D, 1, "R2"); send(8'h4D); // invalid entry is data
        exp_data(ETX, 1, "R2"); send(ETX);
        send_check(0, "R5");
        repeat (3) @(negedge clk);
        char_irq_en = 1'b0; irq_exp = 1'b0;
        repeat (2) @(negedge clk);

        // R5: corrupted check
        exp_data(8'h43, 1, "R5"); send(8'h43);
        exp_data(8'h44, 1, "R5"); send(8'h44);
        exp_data(ETB, 1, "R5"); send(ETB);
        send_check(1, "R5");

        // R3 R4: transparent block
        mode_transp = 1'b1;
        send(DLE); exp_data(STX, 1, "R3"); send(STX);
        exp_data(ETX, 1, "R4"); send(ETX);
        send(DLE); exp_data(DLE, 1, "R3"); send(DLE);
        send(DLE); send(SYN);
        send(SYN);
        exp_data(ENQ, 1, "R4"); send(ENQ);
        exp_data(8'h55, 1, "R3"); send(8'h55);
        send(DLE); exp_data(ITB, 1, "R4"); send(ITB);
        send_check(0, "R3");
        mode_transp = 1'b0;

        // R7: excluded character
        mode_excl_en = 1'b1; excl_char = 8'h58;
        exp_data(8'h58, 0, "R7"); send(8'h58);
        exp_data(8'h59, 1, "R7"); send(8'h59);
        exp_data(ETX, 1, "R7"); send(ETX);
        send_check(0, "R7");
        mode_excl_en = 1'b0;

        // R8: abort then hunt
        exp_data(8'h51, 1, "R8"); send(8'h51);
        exp_data(ENQ, 0, "R8"); push(2, 8'h00, "R8"); send(ENQ);
        chk(hunt_req == 1'b1, "R8", "hunt_req after abort", hunt_req, 1);
        bcrc = '0;
        send(8'h52);                       // discarded in HUNT
        send(SYN);
        exp_data(8'h53, 1, "R8"); send(8'h53);

        // R9: line turnaround clears the check and hunts
        @(negedge clk); line_turn = 1'b1;
        @(negedge clk); line_turn = 1'b0;
        chk(hunt_req == 1'b1, "R9", "hunt_req after turnaround", hunt_req, 1);
        bcrc = '0;
        send(8'h54);                       // discarded in HUNT
        send(SYN);
        exp_data(8'h55, 1, "R9"); send(8'h55);
        exp_data(ETX, 1, "R9"); send(ETX);
        send_check(0, "R9");

        repeat (4) @(negedge clk);
        chk(q_kind.size() == 0, "R11", "scoreboard drained", q_kind.size(), 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule